// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers bytes from an asynchronous serial line that carries no clock. The line idles high. A frame opens with a low start bit, carries eight data bits with the least significant bit first, can add a parity bit, and closes with one or two high stop bits. The receiver produces an internal tick at 64 times the bit rate by dividing the system clock by a fixed amount. It finds the falling edge of the start bit and waits half a bit period to reach the middle of the start bit. From there it samples every later bit exactly one bit period apart, so each sample lands near the middle of its bit.

The line input passes through a two-flop synchronizer before any decision is made. For each complete frame the block presents the byte with a one-cycle strobe. A parity flag and a framing flag travel with that strobe. Parity mode and stop-bit count come from static configuration pins. The receiver captures them at the start edge of each frame.

Top module: `uart_rx_os`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rx_valid`, `rx_parity_err` and `rx_frame_err` are low.
- R2: One bit period is 64 ticks and one tick is `CLKS_PER_TICK` clocks. Data bits are sampled at bit centres. The first bit received becomes `rx_data[0]`.
- R3: `rx_valid` is high for exactly one clock cycle for each frame received.
- R4: If the line is high again at the half-bit check of the start bit, the event is dropped and produces no strobe.
- R5: With `cfg_parity` = 2'b01 (even), one parity bit follows the data. `rx_parity_err` is set when the data bits and the parity bit together hold an odd number of ones.
- R6: With `cfg_parity` = 2'b10 (odd), `rx_parity_err` is set when the data bits and the parity bit together hold an even number of ones.
- R7: With `cfg_parity` = 2'b00 or 2'b11, the frame has no parity bit and `rx_parity_err` stays low.
- R8: A low level at any stop-bit sample sets `rx_frame_err`, and the byte is still presented with the strobe. `rx_parity_err` and `rx_frame_err` are never high without `rx_valid`.
- R9: With `cfg_two_stop` = 1, two stop bits are sampled. A low second stop bit alone sets `rx_frame_err`.
- R10: A new frame starts only on a high-to-low transition. A line held low after a frame produces no further strobe until it has gone high and then low again.
- R11: Frames sent back to back, with no idle time after the last stop bit, are each received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rx_data | output | 8 | Received byte, LSB received first |
| rx_valid | output | 1 | One-cycle strobe per frame |
| rx_parity_err | output | 1 | Parity mismatch, valid with strobe |
| rx_frame_err | output | 1 | Low stop bit seen, valid with strobe |

## Verification
Suppose the bit-phase counter or the bit index goes wrong inside a frame. Then the samples move off the bit centres. The byte presented with that frame's strobe is shifted or corrupted, and the flags can also change. All of this shows up at the next strobe, within one frame time. A sequencer that loses track of the frame either drops the strobe or adds an extra one. A scoreboard that expects exactly one byte per frame sent catches both cases, and it also catches a glitch or a held-low line that is wrongly reported. A strobe that stays high too long shows up at once, one cycle after it rises.

// File: rtl/uart_rx_os_pkg.sv
package uart_rx_os_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_NONE2 = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       par_err;
        logic       frm_err;
    } rx_result_t;

    function automatic logic par_enabled(par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    // data_xor is the reduction XOR of the data bits
    function automatic logic par_mismatch(logic data_xor, logic pbit, par_mode_e m);
        logic total;
        total = data_xor ^ pbit;
        case (m)
            PAR_EVEN: return total;
            PAR_ODD:  return ~total;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int CLKS_PER_TICK = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CLKS_PER_TICK <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_TICK);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)              cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_os_pkg::*;
#(
    parameter int OVS       = 64,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rx,
    input  logic [1:0]           cfg_parity,
    input  logic                 cfg_two_stop,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 out_valid,
    output logic                 out_par_err,
    output logic                 out_frm_err,
    output rx_state_e            st_o,
    output par_mode_e            par_o
);
    localparam int PW = $clog2(OVS);
    localparam int BW = $clog2(DATA_BITS);
    localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(OVS / 2 - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

    rx_state_e            st;
    logic [PW-1:0]        phase;
    logic [BW-1:0]        bit_idx;
    logic                 stop_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit;
    logic                 frm_acc;
    logic                 rx_prev;
    par_mode_e            par_q;
    logic                 two_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            phase       <= '0;
            bit_idx     <= '0;
            stop_idx    <= 1'b0;
            shreg       <= '0;
            par_bit     <= 1'b0;
            frm_acc     <= 1'b0;
            rx_prev     <= 1'b0;
            par_q       <= PAR_NONE;
            two_q       <= 1'b0;
            out_data    <= '0;
            out_valid   <= 1'b0;
            out_par_err <= 1'b0;
            out_frm_err <= 1'b0;
        end else begin
            out_valid   <= 1'b0;
            out_par_err <= 1'b0;
            out_frm_err <= 1'b0;
            if (tick) begin
                rx_prev <= rx;
                unique case (st)
                    ST_IDLE: begin
                        if (rx_prev && !rx) begin
                            st      <= ST_START;
                            phase   <= '0;
                            par_q   <= par_mode_e'(cfg_parity);
                            two_q   <= cfg_two_stop;
                            frm_acc <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (phase == PH_HALF) begin
                            phase   <= '0;
                            bit_idx <= '0;
                            st      <= rx ? ST_IDLE : ST_DATA;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (phase == PH_LAST) begin
                            phase <= '0;
                            shreg <= {rx, shreg[DATA_BITS-1:1]};
                            if (bit_idx == BIT_LAST) begin
                                stop_idx <= 1'b0;
                                st <= par_enabled(par_q) ? ST_PAR : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (phase == PH_LAST) begin
                            phase   <= '0;
                            par_bit <= rx;
                            st      <= ST_STOP;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (phase == PH_LAST) begin
                            phase <= '0;
                            if (two_q && !stop_idx) begin
                                stop_idx <= 1'b1;
                                frm_acc  <= frm_acc | ~rx;
                            end else begin
                                st          <= ST_IDLE;
                                out_valid   <= 1'b1;
                                out_data    <= shreg;
                                out_frm_err <= frm_acc | ~rx;
                                out_par_err <= par_mismatch(^shreg, par_bit, par_q);
                            end
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign st_o  = st;
    assign par_o = par_q;
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
    import uart_rx_os_pkg::*;
#(
    parameter int CLKS_PER_TICK = 16,
    parameter int OVS           = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_two_stop,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_parity_err,
    output logic       rx_frame_err
);
    logic      rx_s;
    logic      tick;
    rx_state_e fsm_state;
    par_mode_e fsm_par;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(rxd), .d_sync(rx_s)
    );

    uart_rx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    uart_rx_fsm #(.OVS(OVS), .DATA_BITS(8)) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .rx(rx_s),
        .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .out_data(rx_data), .out_valid(rx_valid),
        .out_par_err(rx_parity_err), .out_frm_err(rx_frame_err),
        .st_o(fsm_state), .par_o(fsm_par)
    );
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk
    import uart_rx_os_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      rx_valid,
    input logic      rx_parity_err,
    input logic      rx_frame_err,
    input rx_state_e st,
    input par_mode_e par_q
);
    // R1: outputs quiet in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rx_valid && !rx_parity_err && !rx_frame_err));

    // R3: strobe lasts a single cycle
    p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8: flags only accompany the strobe
    p_flags_gated_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_parity_err || rx_frame_err) |-> rx_valid);

    // R7: no parity error when parity is off
    p_no_perr_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !par_enabled(par_q)) |-> !rx_parity_err);

    // R2: a strobe only follows the stop-bit phase
    p_valid_after_stop_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(st) == ST_STOP));

    // R4: leaving the start check goes to idle or data only
    p_start_exit_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_START && st != ST_START) |-> (st == ST_IDLE || st == ST_DATA));
endmodule

bind uart_rx_os uart_rx_os_chk u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
    .st(fsm_state), .par_q(fsm_par)
);

// File: tb/uart_rx_os_test.sv
`timescale 1ns/1ps
module uart_rx_os_test;
    localparam int DIV = 2;
    localparam int BIT = DIV * 64;

    typedef struct {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, rx_parity_err, rx_frame_err;

    int n_cmp = 0;
    int n_bad = 0;
    int n_valid = 0;
    logic prev_valid = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    uart_rx_os #(.CLKS_PER_TICK(DIV)) uut (
        .clk(clk), .rst(rst), .rxd(rxd),
        .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected items as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_valid++;
                check(!prev_valid, "R3", "strobe longer than one cycle", 1, 0);
                if (q.size() == 0) begin
                    check(1'b0, "R4", "unexpected frame", rx_data, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rx_data == e.data, e.tag, "data", rx_data, e.data);
                    check(rx_parity_err == e.perr, e.tag, "parity flag", rx_parity_err, e.perr);
                    check(rx_frame_err == e.ferr, e.tag, "frame flag", rx_frame_err, e.ferr);
                end
            end
            prev_valid = rx_valid;
        end
    end

    task automatic hold(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    // Driver: sends one frame and pushes its expected result
    task automatic send(input logic [7:0] d, input logic [1:0] pm, input logic two,
                        input logic flip_par, input logic s1, input logic s2,
                        input string tag);
        exp_t e;
        logic pbit;
        logic pe;
        pe = (pm == 2'b01) || (pm == 2'b10);
        cfg_parity = pm;
        cfg_two_stop = two;
        pbit = (pm == 2'b10) ? ~(^d) : (^d);
        pbit = pbit ^ flip_par;
        e.data = d;
        e.perr = pe && flip_par;
        e.ferr = !s1 || (two && !s2);
        e.tag = tag;
        q.push_back(e);
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(d[i], BIT);
        if (pe) hold(pbit, BIT);
        hold(s1, BIT);
        if (two) hold(s2, BIT);
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        check(!rx_valid && !rx_parity_err && !rx_frame_err, "R1", "outputs in reset",
              {rx_valid, rx_parity_err, rx_frame_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rx_valid && !rx_parity_err && !rx_frame_err, "R1", "outputs after reset",
              {rx_valid, rx_parity_err, rx_frame_err}, 0);
        hold(1'b1, BIT * 2);

        // R2 plain frames, R7 no parity
        send(8'hA5, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
        hold(1'b1, BIT);
        send(8'h01, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        hold(1'b1, BIT);
        send(8'h80, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
        hold(1'b1, BIT);
        // R5 even parity, good and bad
        send(8'h37, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
        hold(1'b1, BIT);
        send(8'h37, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, "R5");
        hold(1'b1, BIT);
        // R6 odd parity, good and bad
        send(8'hC3, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
        hold(1'b1, BIT);
        send(8'h5E, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
        hold(1'b1, BIT);
        // R8 low stop bit
        send(8'h3C, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        hold(1'b1, BIT * 2);
        // R9 two stop bits, good then second stop low
        send(8'h96, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
        hold(1'b1, BIT);
        send(8'h69, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        hold(1'b1, BIT * 2);

        // R4 short glitch gives nothing
        base = n_valid;
        hold(1'b0, 20);
        hold(1'b1, BIT * 3);
        check(n_valid == base, "R4", "strobes after glitch", n_valid, base);

        // R10 held low after a frame with a low stop bit
        base = n_valid;
        send(8'hF0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        hold(1'b0, BIT * 4);
        hold(1'b1, BIT * 2);
        check(n_valid == base + 1, "R10", "strobes for held-low line", n_valid, base + 1);

        // R11 back to back frames
        base = n_valid;
        send(8'h11, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        send(8'hEE, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        send(8'h7F, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        hold(1'b1, BIT * 2);
        check(n_valid == base + 3, "R11", "back-to-back strobes", n_valid, base + 3);
        check(q.size() == 0, "R3", "frames still pending", q.size(), 0);

        finish_up();
    end
endmodule